// File: doc/BRIEF.md
# Sound Event Interrupt Prioritizer

This block gathers event strobes from up to eight numbered sources inside a sound subsystem and folds them into a single fast-interrupt request for the embedded processor. Each source owns one bit of a pending mask. A small register names the lowest-numbered event still pending, and the processor reads it to find out which source needs service.

Pending events are not acknowledged bit by bit. The processor issues clear accesses instead, and only every fourth access retires one event. That event is always the lowest-numbered pending bit. After a retirement the event register moves on to the next pending index. When the last event is retired, the interrupt line drops.

At reset the timer source, event 2, is already pending. The processor therefore sees an interrupt as soon as reset is released.

Top module: `snd_evt_irq_ctrl`

## Requirements
- R1: A high bit i on `evt_strobe` marks event i pending. Several strobe bits high in the same cycle are all recorded.
- R2: `fiq_o` rises on the clock edge that records an event while nothing was pending. It stays high as long as any event is pending.
- R3: On a strobe, `evt_num` takes the lowest strobed index in two cases: the mask was empty before the strobe, or that index is lower than the current `evt_num`. Otherwise `evt_num` keeps its value.
- R4: Only every fourth `clr_access` pulse performs a retirement. The access count advances even while nothing is pending, and it returns to zero on the fourth access.
- R5: A retirement removes the lowest-numbered pending bit. `evt_num` then shows the lowest index that remains pending.
- R6: Whenever the pending mask is empty, `fiq_o` is low and `evt_num` reads 0.
- R7: After reset, event 2 is pending, `evt_num` reads 2, `fiq_o` is high and the clear-access count is zero.
- R8: If a strobe and a retirement fall in the same cycle, both take effect. The retired bit is cleared first and the strobed bits are set afterwards, so re-strobing the retired bit keeps it pending.
- R9: Every output change caused by a strobe, a clear access or reset release shows up on the first rising clock edge after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 8 | One strobe bit per event source; bit i is event i |
| clr_access | input | 1 | One-cycle pulse for each processor clear access |
| evt_num | output | 3 | Lowest pending event index, or 0 when nothing is pending |
| fiq_o | output | 1 | Fast-interrupt request to the processor |

## Verification
Every result of this block is registered exactly once, so a strobe or a clear access presented before a rising edge shows up on `evt_num` and `fiq_o` just after that edge. The bench therefore drives its inputs on the falling edge and compares the outputs on the next falling edge, one full cycle later. Retirements land only on the fourth clear pulse. To confirm that the first three pulses change nothing, the bench checks the outputs after every single pulse and not only after groups of four.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
    localparam int EVT_N = 8;
    localparam int IDX_W = $clog2(EVT_N);

    typedef struct packed {
        logic [EVT_N-1:0] pend;
        logic [IDX_W-1:0] evt;
        logic             fiq;
    } irq_state_t;
endpackage

// File: rtl/snd_irq_prio_enc.sv
module snd_irq_prio_enc #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top index down, so the lowest set bit is the last one written.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/snd_irq_clr_div.sv
module snd_irq_clr_div #(
    parameter int DIV = 4,
    parameter int CW  = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic          step_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        step_o = clr_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clr_i) cnt_d = step_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/snd_evt_irq_ctrl.sv
module snd_evt_irq_ctrl
    import snd_irq_pkg::*;
#(
    parameter int TIMER_EVT      = 2,
    parameter int CLR_PER_RETIRE = 4,
    localparam int CW            = $clog2(CLR_PER_RETIRE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_strobe,
    input  logic             clr_access,
    output logic [IDX_W-1:0] evt_num,
    output logic             fiq_o
);
    irq_state_t st_d, st_q;

    logic             step;
    logic [CW-1:0]    clr_cnt;
    logic [EVT_N-1:0] low_bit, kept;
    logic             kept_any, new_any;
    logic [IDX_W-1:0] kept_idx, new_idx, base_idx;

    snd_irq_clr_div #(.DIV(CLR_PER_RETIRE), .CW(CW)) u_div (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_access),
        .step_o(step), .cnt_o(clr_cnt)
    );

    // Mask left over once the optional retirement has been applied.
    assign low_bit = st_q.pend & (~st_q.pend + 1'b1);
    assign kept    = step ? (st_q.pend & ~low_bit) : st_q.pend;

    snd_irq_prio_enc #(.N(EVT_N), .IW(IDX_W)) u_enc_kept (
        .vec_i(kept), .any_o(kept_any), .idx_o(kept_idx)
    );

    snd_irq_prio_enc #(.N(EVT_N), .IW(IDX_W)) u_enc_new (
        .vec_i(evt_strobe), .any_o(new_any), .idx_o(new_idx)
    );

    always_comb begin
        st_d      = st_q;
        base_idx  = step ? (kept_any ? kept_idx : '0) : st_q.evt;
        st_d.pend = kept | evt_strobe;
        st_d.evt  = base_idx;
        if (new_any && (!kept_any || new_idx < base_idx)) st_d.evt = new_idx;
        st_d.fiq  = |st_d.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= EVT_N'(1) << TIMER_EVT;
            st_q.evt  <= IDX_W'(TIMER_EVT);
            st_q.fiq  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_num = st_q.evt;
    assign fiq_o   = st_q.fiq;
endmodule

// File: rtl/snd_irq_ctrl_chk.sv
module snd_irq_ctrl_chk
    import snd_irq_pkg::*;
#(
    parameter int CLR_PER_RETIRE = 4,
    localparam int CW            = $clog2(CLR_PER_RETIRE)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_N-1:0] evt_strobe,
    input logic             clr_access,
    input logic [EVT_N-1:0] pend,
    input logic [CW-1:0]    clr_cnt,
    input logic [IDX_W-1:0] evt_num,
    input logic             fiq_o
);
    logic [EVT_N-1:0] below;
    assign below = (EVT_N'(1) << evt_num) - 1'b1;

    a_r2_rise_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> $past(pend) == '0);

    a_r3_lowest_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (pend[evt_num] && (pend & below) == '0));

    a_r4_no_early_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_access && clr_cnt != CW'(CLR_PER_RETIRE - 1) && evt_strobe == '0)
        |=> pend == $past(pend));

    a_r5_one_retired: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_access && clr_cnt == CW'(CLR_PER_RETIRE - 1) && pend != '0 && evt_strobe == '0)
        |=> $countones(pend) == $countones($past(pend)) - 1);

    a_r6_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (evt_num == '0 && !fiq_o));

    a_r8_strobe_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_strobe != '0) |=> (pend & $past(evt_strobe)) == $past(evt_strobe));
endmodule

bind snd_evt_irq_ctrl snd_irq_ctrl_chk #(.CLR_PER_RETIRE(CLR_PER_RETIRE)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .clr_access(clr_access),
    .pend(st_q.pend), .clr_cnt(clr_cnt), .evt_num(evt_num), .fiq_o(fiq_o)
);

// File: tb/snd_evt_irq_ctrl_test.sv
module snd_evt_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_strobe = '0;
    logic       clr_access = 1'b0;
    logic [2:0] evt_num;
    logic       fiq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    snd_evt_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .clr_access(clr_access), .evt_num(evt_num), .fiq_o(fiq_o)
    );

    // Row layout: {strobe[7:0], clear, expected evt_num[2:0], expected fiq}
    localparam int ROWS = 31;
    localparam logic [12:0] VEC [ROWS] = '{
        {8'h20, 1'b0, 3'd2, 1'b1},  // R1 add 5, timer 2 stays lowest (R3)
        {8'h01, 1'b0, 3'd0, 1'b1},  // R3 event 0 is lower
        {8'h80, 1'b0, 3'd0, 1'b1},  // R3 higher index leaves value
        {8'h00, 1'b1, 3'd0, 1'b1},  // R4 clear 1
        {8'h00, 1'b1, 3'd0, 1'b1},  // R4 clear 2
        {8'h00, 1'b1, 3'd0, 1'b1},  // R4 clear 3
        {8'h00, 1'b1, 3'd2, 1'b1},  // R5 clear 4 retires 0
        {8'h00, 1'b1, 3'd2, 1'b1},
        {8'h00, 1'b1, 3'd2, 1'b1},
        {8'h00, 1'b1, 3'd2, 1'b1},
        {8'h00, 1'b1, 3'd5, 1'b1},  // R5 retires 2
        {8'h08, 1'b0, 3'd3, 1'b1},  // R3 new 3 below 5
        {8'h00, 1'b1, 3'd3, 1'b1},
        {8'h00, 1'b1, 3'd3, 1'b1},
        {8'h00, 1'b1, 3'd3, 1'b1},
        {8'h08, 1'b1, 3'd3, 1'b1},  // R8 retire 3 and re-strobe 3
        {8'h00, 1'b1, 3'd3, 1'b1},
        {8'h00, 1'b1, 3'd3, 1'b1},
        {8'h00, 1'b1, 3'd3, 1'b1},
        {8'h00, 1'b1, 3'd5, 1'b1},  // R5 retires 3 for real
        {8'h00, 1'b1, 3'd5, 1'b1},
        {8'h00, 1'b1, 3'd5, 1'b1},
        {8'h00, 1'b1, 3'd5, 1'b1},
        {8'h00, 1'b1, 3'd7, 1'b1},  // R5 retires 5
        {8'h00, 1'b1, 3'd7, 1'b1},
        {8'h00, 1'b1, 3'd7, 1'b1},
        {8'h00, 1'b1, 3'd7, 1'b1},
        {8'h00, 1'b1, 3'd0, 1'b0},  // R6 last retire drops fiq
        {8'h00, 1'b0, 3'd0, 1'b0},  // R6 idle stays empty
        {8'h50, 1'b0, 3'd4, 1'b1},  // R1 two strobes at once, R2 fiq rises
        {8'h02, 1'b0, 3'd1, 1'b1}   // R9 next edge shows event 1
    };

    function automatic string tag_of(int row);
        case (row)
            0, 29:                                      return "R1";
            1, 2, 11:                                   return "R3";
            3, 4, 5:                                    return "R4";
            6, 10, 19, 23:                              return "R5";
            15:                                         return "R8";
            27, 28:                                     return "R6";
            30:                                         return "R9";
            default:                                    return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [2:0] exp_evt, logic exp_fiq);
        n_chk++;
        if (evt_num !== exp_evt || fiq_o !== exp_fiq) begin
            n_bad++;
            $display("FAIL %s: evt_num=%0d fiq=%0b expected evt_num=%0d fiq=%0b",
                     req, evt_num, fiq_o, exp_evt, exp_fiq);
        end
    endtask

    // Inputs change on a falling edge; results are compared on the next one.
    task automatic apply(logic [7:0] s, logic c);
        evt_strobe = s;
        clr_access = c;
        @(negedge clk);
        evt_strobe = '0;
        clr_access = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R7", 3'd2, 1'b1);

        for (int i = 0; i < ROWS; i++) begin
            apply(VEC[i][12:5], VEC[i][4]);
            check(tag_of(i), VEC[i][3:1], VEC[i][0]);
        end

        // R7: reset in mid-run brings the timer back and zeroes the clear count
        apply(8'h00, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7", 3'd2, 1'b1);
        for (int k = 0; k < 3; k++) begin
            apply(8'h00, 1'b1);
            check("R4", 3'd2, 1'b1);
        end
        apply(8'h00, 1'b1);
        check("R6", 3'd0, 1'b0);

        // R4: clear accesses count while empty, so a later retire comes early
        apply(8'h00, 1'b1);
        apply(8'h00, 1'b1);
        check("R6", 3'd0, 1'b0);
        apply(8'h01, 1'b0);
        check("R2", 3'd0, 1'b1);
        apply(8'h08, 1'b0);
        check("R3", 3'd0, 1'b1);
        apply(8'h00, 1'b1);
        check("R4", 3'd0, 1'b1);
        apply(8'h00, 1'b1);
        check("R4", 3'd3, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule